// File: doc/BRIEF.md
# Parameter Limit Comparator with Persistence Alarms

This block watches a stream of computed parameter values. Each value arrives with a parameter index and is compared against that parameter's alarm band and warning band, each band being an inclusive upper and lower signed bound. An instantaneous alarm flag follows the latest verdict for each parameter. A delayed alarm flag rises only when the violation has lasted for that parameter's programmed number of 1 ms ticks. The two flag vectors are driven in parallel toward station control.

Every accepted value also goes into an output queue for a remote monitoring system. The entry holds the index, the value, the instantaneous alarm, the delayed alarm and a warning bit. The warning bit is worked out with the same persistence rule, using the warning band and the warning delay. It is only forwarded and never reaches the alarm vectors.

Bands and delays are loaded through a write port that addresses a parameter and a field. A write to any band or delay field of a parameter restarts that parameter's persistence counting.

Top module: `limit_watch`

## Requirements
- R1: After reset, alarm_now and alarm_late are all zero, fifo_empty is 1, and fifo_full and fifo_ovf are 0.
- R2: A sample is out of band when its value is above the upper bound or below the lower bound; a value equal to either bound is in band. alarm_now[idx] shows that verdict from the second rising edge after the sample is presented (the capture edge plus one).
- R3: An in-band sample clears the instantaneous flag, the delayed flag and the persistence counter of its parameter in that same update.
- R4: While a parameter's instantaneous flag is set, each tick_ms seen on a later edge adds one to its counter. An out-of-band sample sets the delayed flag only if the previous sample of that parameter was also out of band and the counter has reached the programmed delay. A tick coinciding with an update is not counted before that update's decision.
- R5: With a delay of zero, the delayed flag rises at the second consecutive out-of-band sample.
- R6: The persistence counter saturates at 65535 and does not wrap, so a delay of 65535 is reachable.
- R7: The warning bit applies the R3 to R5 rules with the warning band (fields 3 and 4) and the warning delay (field 5). It never affects alarm_now or alarm_late.
- R8: Every sample pushes one entry, packed as bits [21:19] index, [18:3] value, [2] instantaneous alarm, [1] delayed alarm, [0] warning. The entry shows the flag values produced by that update.
- R9: The queue holds 16 entries. A push while it is full is dropped and sets fifo_ovf, which stays set until reset; the stored entries are kept in order.
- R10: Field codes are 0 alarm upper, 1 alarm lower, 2 alarm delay, 3 warning upper, 4 warning lower, 5 warning delay. A write to codes 0 to 5 clears that parameter's counters and delayed flags at the write edge and leaves alarm_now unchanged. Writes with codes 6 and 7 change nothing.
- R11: Every parameter's counter runs at the same time as the others, so ticks accrue for all parameters that are in violation.
- R12: fifo_data shows the oldest entry from the rising edge that samples fifo_pop with fifo_empty low. fifo_empty rises when the last entry has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle 1 ms strobe for persistence counting |
| smp_valid | input | 1 | A parameter sample is presented |
| smp_idx | input | 3 | Parameter index of the sample |
| smp_value | input | 16 | Signed parameter value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Parameter addressed by the write |
| cfg_field | input | 3 | Field code (see R10) |
| cfg_data | input | 16 | Bound (signed) or delay (unsigned ticks) |
| alarm_now | output | 8 | Instantaneous alarm per parameter |
| alarm_late | output | 8 | Delayed alarm per parameter |
| fifo_pop | input | 1 | Take the oldest queue entry |
| fifo_data | output | 22 | Entry taken by the last pop |
| fifo_empty | output | 1 | Queue holds no entry |
| fifo_full | output | 1 | Queue holds 16 entries |
| fifo_ovf | output | 1 | Sticky flag: an entry was dropped |

## Verification
A sample is captured on one rising edge, and its bounds are read from block RAM on that edge. Its flags and queue entry are therefore due on the following edge. The bench drives at falling edges and, after a sample, waits through both rising edges before it reads alarm_now, alarm_late and the queue. A popped entry is due on the edge that samples fifo_pop, and a configuration clear is due on the write edge, so both are read at the falling edge just after. Tick pulses are placed only between completed updates, which keeps the expected counter values for the persistence checks exact.

// File: rtl/lw_pkg.sv
package lw_pkg;
  localparam int FLD_W      = 3;
  localparam int NUM_FIELDS = 6;
  localparam int FLD_AHI    = 0;
  localparam int FLD_ALO    = 1;
  localparam int FLD_ADLY   = 2;
  localparam int FLD_WHI    = 3;
  localparam int FLD_WLO    = 4;
  localparam int FLD_WDLY   = 5;
endpackage

// File: rtl/lw_ram.sv
module lw_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // read-first simple dual port, suitable for block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lw_persist.sv
module lw_persist #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             upd,
  input  logic             viol,
  input  logic             clr,
  input  logic [CNT_W-1:0] dly_lim,
  output logic             act,
  output logic             late,
  output logic             late_nxt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt, cnt_nxt, cnt_inc;
  logic             act_nxt;

  assign cnt_inc = (tick && (cnt != CNT_MAX)) ? cnt + 1'b1 : cnt;

  always_comb begin
    act_nxt  = act;
    late_nxt = late;
    cnt_nxt  = cnt;
    if (upd) begin
      act_nxt  = viol;
      late_nxt = viol && act && (cnt >= dly_lim);
      cnt_nxt  = (viol && act) ? cnt_inc : '0;
    end else if (act) begin
      cnt_nxt = cnt_inc;
    end
    if (clr) begin
      late_nxt = 1'b0;
      cnt_nxt  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act  <= 1'b0;
      late <= 1'b0;
      cnt  <= '0;
    end else begin
      act  <= act_nxt;
      late <= late_nxt;
      cnt  <= cnt_nxt;
    end
  end

  assert_late_needs_act_R4: assert property (@(posedge clk) disable iff (rst)
    late |-> act);
  assert_inband_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (upd && !viol) |=> (!act && !late));
  assert_cfg_clears_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!late && cnt == '0));
  assert_cnt_saturates_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !upd && !clr) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/lw_fifo.sv
module lw_fifo #(
  parameter int W     = 22,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         ovf
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  lw_ram #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk  (clk),
    .we   (push_ok),
    .waddr(wptr),
    .wdata(din),
    .re   (pop_ok),
    .raddr(rptr),
    .rdata(dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && full) ovf <= 1'b1;
    end
  end

  assert_ovf_on_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> ovf);
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
endmodule

// File: rtl/limit_watch.sv
module limit_watch #(
  parameter int NUM_PARAM  = 8,
  parameter int DATA_W     = 16,
  parameter int DLY_W      = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int IDX_W      = $clog2(NUM_PARAM),
  parameter int ENT_W      = IDX_W + DATA_W + 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick_ms,
  input  logic                     smp_valid,
  input  logic [IDX_W-1:0]         smp_idx,
  input  logic signed [DATA_W-1:0] smp_value,
  input  logic                     cfg_we,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [lw_pkg::FLD_W-1:0] cfg_field,
  input  logic [DATA_W-1:0]        cfg_data,
  output logic [NUM_PARAM-1:0]     alarm_now,
  output logic [NUM_PARAM-1:0]     alarm_late,
  input  logic                     fifo_pop,
  output logic [ENT_W-1:0]         fifo_data,
  output logic                     fifo_empty,
  output logic                     fifo_full,
  output logic                     fifo_ovf
);
  import lw_pkg::*;

  // capture stage: sample registered while its bounds are read
  logic                     s1_vld;
  logic [IDX_W-1:0]         s1_idx;
  logic signed [DATA_W-1:0] s1_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_idx <= '0;
      s1_val <= '0;
    end else begin
      s1_vld <= smp_valid;
      s1_idx <= smp_idx;
      s1_val <= smp_value;
    end
  end

  // one bound/delay table per field
  logic [DATA_W-1:0] lim [NUM_FIELDS];

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_tbl
    lw_ram #(.W(DATA_W), .DEPTH(NUM_PARAM), .AW(IDX_W)) u_tbl (
      .clk  (clk),
      .we   (cfg_we && (cfg_field == FLD_W'(f))),
      .waddr(cfg_idx),
      .wdata(cfg_data),
      .re   (1'b1),
      .raddr(smp_idx),
      .rdata(lim[f])
    );
  end

  // one shared comparator pair per band
  logic a_viol, w_viol;
  logic [DLY_W-1:0] a_dly, w_dly;

  assign a_viol = (s1_val > $signed(lim[FLD_AHI])) || (s1_val < $signed(lim[FLD_ALO]));
  assign w_viol = (s1_val > $signed(lim[FLD_WHI])) || (s1_val < $signed(lim[FLD_WLO]));
  assign a_dly  = lim[FLD_ADLY][DLY_W-1:0];
  assign w_dly  = lim[FLD_WDLY][DLY_W-1:0];

  logic                 cfg_hit;
  logic [NUM_PARAM-1:0] w_act, w_late, a_late_nxt, w_late_nxt;

  assign cfg_hit = cfg_we && (cfg_field < FLD_W'(NUM_FIELDS));

  for (genvar p = 0; p < NUM_PARAM; p++) begin : g_par
    logic upd_p, clr_p;
    assign upd_p = s1_vld && (s1_idx == IDX_W'(p));
    assign clr_p = cfg_hit && (cfg_idx == IDX_W'(p));

    lw_persist #(.CNT_W(DLY_W)) u_alarm (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick_ms),
      .upd     (upd_p),
      .viol    (a_viol),
      .clr     (clr_p),
      .dly_lim (a_dly),
      .act     (alarm_now[p]),
      .late    (alarm_late[p]),
      .late_nxt(a_late_nxt[p])
    );

    lw_persist #(.CNT_W(DLY_W)) u_warn (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick_ms),
      .upd     (upd_p),
      .viol    (w_viol),
      .clr     (clr_p),
      .dly_lim (w_dly),
      .act     (w_act[p]),
      .late    (w_late[p]),
      .late_nxt(w_late_nxt[p])
    );
  end

  logic [ENT_W-1:0] entry;
  assign entry = {s1_idx, s1_val, a_viol, a_late_nxt[s1_idx], w_late_nxt[s1_idx]};

  lw_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_out (
    .clk  (clk),
    .rst  (rst),
    .push (s1_vld),
    .din  (entry),
    .pop  (fifo_pop),
    .dout (fifo_data),
    .empty(fifo_empty),
    .full (fifo_full),
    .ovf  (fifo_ovf)
  );

  assert_now_follows_update_R2: assert property (@(posedge clk) disable iff (rst)
    s1_vld |=> (alarm_now[$past(s1_idx)] == $past(a_viol)));
  assert_warn_isolated_R7: assert property (@(posedge clk) disable iff (rst)
    (!s1_vld && !cfg_hit) |=> $stable(alarm_now));
endmodule

// File: tb/limit_watch_bench.sv
module limit_watch_bench;
  logic        clk = 1'b0;
  logic        rst, tick_ms, smp_valid, cfg_we, fifo_pop;
  logic [2:0]  smp_idx, cfg_idx, cfg_field;
  logic signed [15:0] smp_value;
  logic [15:0] cfg_data;
  logic [7:0]  alarm_now, alarm_late;
  logic [21:0] fifo_data;
  logic        fifo_empty, fifo_full, fifo_ovf;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  limit_watch u_limit_watch (
    .clk(clk), .rst(rst), .tick_ms(tick_ms),
    .smp_valid(smp_valid), .smp_idx(smp_idx), .smp_value(smp_value),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_field(cfg_field), .cfg_data(cfg_data),
    .alarm_now(alarm_now), .alarm_late(alarm_late),
    .fifo_pop(fifo_pop), .fifo_data(fifo_data),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_ovf(fifo_ovf)
  );

  // {ticks before, idx, value, 1'b0, now, late, warn}
  localparam logic [31:0] VEC [14] = '{
    {8'd0, 4'd0, 16'h0064, 4'b0000},
    {8'd0, 4'd0, 16'hFF9C, 4'b0001},
    {8'd0, 4'd0, 16'h0065, 4'b0101},
    {8'd2, 4'd0, 16'h0096, 4'b0101},
    {8'd1, 4'd0, 16'hFF9B, 4'b0111},
    {8'd0, 4'd0, 16'h0000, 4'b0000},
    {8'd5, 4'd0, 16'hFF38, 4'b0100},
    {8'd0, 4'd0, 16'hFF38, 4'b0101},
    {8'd3, 4'd0, 16'h01F4, 4'b0111},
    {8'd0, 4'd0, 16'hFF9C, 4'b0001},
    {8'd0, 4'd3, 16'hFFF6, 4'b0000},
    {8'd0, 4'd3, 16'hFFEB, 4'b0100},
    {8'd0, 4'd3, 16'hFFE7, 4'b0110},
    {8'd2, 4'd3, 16'hFFF7, 4'b0111}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] idx, input logic [2:0] fld, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_field = fld; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_param(input logic [2:0] idx, input logic [15:0] ahi, input logic [15:0] alo,
                           input logic [15:0] ad, input logic [15:0] whi, input logic [15:0] wlo,
                           input logic [15:0] wd);
    cfg(idx, 3'd0, ahi); cfg(idx, 3'd1, alo); cfg(idx, 3'd2, ad);
    cfg(idx, 3'd3, whi); cfg(idx, 3'd4, wlo); cfg(idx, 3'd5, wd);
  endtask

  task automatic sample(input logic [2:0] idx, input logic [15:0] v);
    @(negedge clk);
    smp_valid = 1'b1; smp_idx = idx; smp_value = v;
    @(negedge clk);
    smp_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_ms = 1'b1;
      repeat (n) @(negedge clk);
      tick_ms = 1'b0;
    end
  endtask

  task automatic pop(output logic [21:0] e);
    @(negedge clk);
    fifo_pop = 1'b1;
    @(negedge clk);
    fifo_pop = 1'b0;
    e = fifo_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [21:0] e;
    rst = 1'b1; tick_ms = 1'b0; smp_valid = 1'b0; cfg_we = 1'b0; fifo_pop = 1'b0;
    smp_idx = '0; smp_value = '0; cfg_idx = '0; cfg_field = '0; cfg_data = '0;
    do_reset();
    chk("R1 alarm_now", {24'd0, alarm_now}, 32'd0);
    chk("R1 alarm_late", {24'd0, alarm_late}, 32'd0);
    chk("R1 empty/full/ovf", {29'd0, fifo_empty, fifo_full, fifo_ovf}, 32'b100);

    set_param(3'd0, 16'd100, -16'sd100, 16'd3, 16'd50, -16'sd50, 16'd0);
    set_param(3'd3, -16'sd10, -16'sd20, 16'd0, -16'sd12, -16'sd18, 16'd2);

    // table walk: R2 R3 R4 R5 R7 R8 R12
    for (int i = 0; i < 14; i++) begin
      logic [31:0] v;
      logic [2:0]  ix;
      v  = VEC[i];
      ix = v[22:20];
      ticks(int'(v[31:24]));
      sample(ix, v[19:4]);
      chk($sformatf("R2 now vec %0d", i), {31'd0, alarm_now[ix]}, {31'd0, v[2]});
      chk($sformatf("R4 late vec %0d", i), {31'd0, alarm_late[ix]}, {31'd0, v[1]});
      pop(e);
      chk($sformatf("R7 warn vec %0d", i), {31'd0, e[0]}, {31'd0, v[0]});
      chk($sformatf("R8 entry vec %0d", i), {10'd0, e}, {10'd0, ix, v[19:4], v[2:0]});
    end
    chk("R12 empty after drain", {31'd0, fifo_empty}, 32'd1);

    // R10: ignored field codes and clearing writes
    set_param(3'd1, 16'd10, -16'sd10, 16'd1, 16'h7FFF, 16'h8000, 16'd0);
    sample(3'd1, 16'd20); pop(e);
    chk("R10 setup now", {31'd0, alarm_now[1]}, 32'd1);
    ticks(2);
    sample(3'd1, 16'd20); pop(e);
    chk("R10 setup late", {31'd0, alarm_late[1]}, 32'd1);
    cfg(3'd1, 3'd7, 16'd0);
    chk("R10 code 7 keeps late", {31'd0, alarm_late[1]}, 32'd1);
    sample(3'd1, 16'd20); pop(e);
    chk("R10 code 7 keeps bounds", {30'd0, alarm_now[1], alarm_late[1]}, 32'b11);
    cfg(3'd1, 3'd2, 16'd1);
    chk("R10 write clears late", {31'd0, alarm_late[1]}, 32'd0);
    chk("R10 write keeps now", {31'd0, alarm_now[1]}, 32'd1);
    sample(3'd1, 16'd20); pop(e);
    chk("R10 counter restarted", {30'd0, alarm_now[1], alarm_late[1]}, 32'b10);

    // R11: two parameters counting together
    set_param(3'd2, 16'd10, -16'sd10, 16'd2, 16'h7FFF, 16'h8000, 16'd0);
    set_param(3'd4, 16'd10, -16'sd10, 16'd2, 16'h7FFF, 16'h8000, 16'd0);
    sample(3'd2, -16'sd50); pop(e);
    sample(3'd4, -16'sd50); pop(e);
    ticks(2);
    sample(3'd2, -16'sd50); pop(e);
    sample(3'd4, -16'sd50); pop(e);
    chk("R11 both late", {30'd0, alarm_late[4], alarm_late[2]}, 32'b11);
    chk("R8 entry late p4", {10'd0, e}, {10'd0, 3'd4, 16'hFFCE, 3'b110});

    // R6: saturation, a wrapping counter would hold 4 here
    set_param(3'd5, 16'd10, -16'sd10, 16'hFFFF, 16'h7FFF, 16'h8000, 16'd0);
    sample(3'd5, 16'd20); pop(e);
    chk("R6 first late low", {31'd0, alarm_late[5]}, 32'd0);
    ticks(65540);
    sample(3'd5, 16'd20); pop(e);
    chk("R6 saturated late", {31'd0, alarm_late[5]}, 32'd1);

    // R1 again, then R9 overflow and R12 order
    set_param(3'd6, 16'd100, -16'sd100, 16'd0, 16'h7FFF, 16'h8000, 16'd0);
    do_reset();
    chk("R1 reset clears alarms", {16'd0, alarm_now, alarm_late}, 32'd0);
    chk("R1 reset empties queue", {29'd0, fifo_empty, fifo_full, fifo_ovf}, 32'b100);
    for (int k = 0; k < 16; k++) sample(3'd6, 16'(k));
    chk("R9 full no ovf", {30'd0, fifo_full, fifo_ovf}, 32'b10);
    sample(3'd6, 16'd16);
    chk("R9 ovf set", {30'd0, fifo_full, fifo_ovf}, 32'b11);
    for (int k = 0; k < 16; k++) begin
      pop(e);
      chk($sformatf("R9 order %0d", k), {16'd0, e[18:3]}, 32'(k));
    end
    chk("R12 empty at end", {31'd0, fifo_empty}, 32'd1);
    chk("R9 ovf sticky", {31'd0, fifo_ovf}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule